// File: doc/BRIEF.md
# Two-Port Clocked Word Memory with Selectable Output Staging

This block is a shared word store that two independent agents reach at the same time, each through its own port and its own clock. Every port registers its address, write data, lane enables and control bits on the rising edge. The port then performs a read or a per-lane write in the cycle that follows. Each lane is nine bits wide, and four lanes make one 36-bit word by default. A port takes part in a cycle only when both of its select inputs are active. Having two selects lets several instances share one address space without any external decode logic.

Each port chooses its own output timing. In flow-through timing the read word appears in the cycle after the capture edge. In pipelined timing a further output register adds one cycle. Because the lane enables and selects pass through that register too, a deselect takes two edges to reach the pins. There is no real tri-state pin. The outputs are a data bus plus one drive flag per lane, and the surrounding logic uses those flags to build the pad drivers. The address width is a parameter: 16 gives 64K words, and the default is smaller.

Top module: `dpr_dual_sync_ram`

## Requirements
- R1: While a port's reset is asserted, and in the first cycle after release, all of that port's drive flags are low.
- R2: A write changes only the 9-bit lanes whose enable bit is 1 (bit n covers data bits 9n+8..9n). The other lanes of that word keep their stored value.
- R3: A port acts only when select-0 is low and select-1 is high in the same cycle. Otherwise it writes nothing and raises no drive flag for that access.
- R4: In flow-through mode (pipe input 0), a read captured at edge k drives its word after edge k, and it drives only the lanes that were enabled at capture.
- R5: In pipelined mode (pipe input 1), the same read drives after edge k+1. A deselect captured at edge k therefore clears the flags only after edge k+1.
- R6: Drive flag n is high only when output-enable (active low, acting combinationally) is low and the output stage holds a selected read with lane n enabled.
- R7: Both ports can read the same address in the same cycle, and both receive the stored word.
- R8: When both ports write the same address in the same cycle, the left port's data is stored on every lane that both ports enable. A lane enabled by only one port takes that port's data.
- R9: A read captured at the same edge as a write to that address on the other port returns the contents from before the write.
- R10: A write captured at edge k is visible to a read on either port captured at edge k+1 or later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_l | input | 1 | Left port clock |
| rst_n_l | input | 1 | Left port asynchronous reset, active low |
| pipe_l | input | 1 | Left output timing: 1 pipelined, 0 flow-through |
| ce0_n_l | input | 1 | Left select, active low |
| ce1_l | input | 1 | Left select, active high |
| rw_l | input | 1 | Left direction: 1 read, 0 write |
| be_l | input | LANES | Left lane enables |
| addr_l | input | ADDR_W | Left word address |
| din_l | input | LANES*LANE_W | Left write data |
| oe_n_l | input | 1 | Left output enable, active low |
| dout_l | output | LANES*LANE_W | Left read data |
| dout_en_l | output | LANES | Left per-lane drive flags |
| clk_r | input | 1 | Right port clock |
| rst_n_r | input | 1 | Right port asynchronous reset, active low |
| pipe_r | input | 1 | Right output timing: 1 pipelined, 0 flow-through |
| ce0_n_r | input | 1 | Right select, active low |
| ce1_r | input | 1 | Right select, active high |
| rw_r | input | 1 | Right direction: 1 read, 0 write |
| be_r | input | LANES | Right lane enables |
| addr_r | input | ADDR_W | Right word address |
| din_r | input | LANES*LANE_W | Right write data |
| oe_n_r | input | 1 | Right output enable, active low |
| dout_r | output | LANES*LANE_W | Right read data |
| dout_en_r | output | LANES | Right per-lane drive flags |

## Verification
The hardest case to reach from the ports is two requests colliding on one word at one edge: two writes with overlapping lane masks, or a write on one port with a read on the other. Both ports are driven from one clock, so same-edge collisions are exact. A random phase limits addresses to four words and draws lane masks, operations, selects and output-enable freely, which makes collisions frequent. The bench's reference model commits the right port's write first and the left port's second, then checks which data comes back. The pipelined and flow-through settings are swapped between phases so that each port's deselect timing is checked in both modes.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
   localparam int DEF_ADDR_W = 8;
   localparam int DEF_LANE_W = 9;
   localparam int DEF_LANES  = 4;

   typedef enum logic {
      OUT_FLOW = 1'b0,
      OUT_PIPE = 1'b1
   } out_mode_e;
endpackage

// File: rtl/dpr_port_front.sv
module dpr_port_front #(
   parameter int ADDR_W = 8,
   parameter int LANE_W = 9,
   parameter int LANES  = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      ce0_n,
   input  logic                      ce1,
   input  logic                      rw,
   input  logic [LANES-1:0]          be,
   input  logic [ADDR_W-1:0]         addr,
   input  logic [LANES*LANE_W-1:0]   din,
   output logic [LANES-1:0]          wr_lanes,
   output logic [LANES-1:0]          rd_lanes,
   output logic [ADDR_W-1:0]         addr_q,
   output logic [LANES*LANE_W-1:0]   din_q
);
   logic             ce0_n_q;
   logic             ce1_q;
   logic             rw_q;
   logic [LANES-1:0] be_q;
   logic             selected;

   // capture stage: every input is registered on the port clock
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ce0_n_q <= 1'b1;
         ce1_q   <= 1'b0;
         rw_q    <= 1'b1;
         be_q    <= '0;
         addr_q  <= '0;
         din_q   <= '0;
      end else begin
         ce0_n_q <= ce0_n;
         ce1_q   <= ce1;
         rw_q    <= rw;
         be_q    <= be;
         addr_q  <= addr;
         din_q   <= din;
      end
   end

   always_comb begin
      selected = ~ce0_n_q & ce1_q;
      wr_lanes = {LANES{selected & ~rw_q}} & be_q;
      rd_lanes = {LANES{selected &  rw_q}} & be_q;
   end
endmodule

// File: rtl/dpr_xor_bank.sv
module dpr_xor_bank #(
   parameter int ADDR_W = 8,
   parameter int LANE_W = 9,
   parameter int LANES  = 4
) (
   input  logic                      clk,
   input  logic [LANES-1:0]          we_lanes,
   input  logic [ADDR_W-1:0]         waddr,
   input  logic [LANES*LANE_W-1:0]   wdata,
   input  logic [ADDR_W-1:0]         raddr_a,
   input  logic [ADDR_W-1:0]         raddr_b,
   output logic [LANES*LANE_W-1:0]   rdata_a,
   output logic [LANES*LANE_W-1:0]   rdata_b
);
   localparam int DEPTH = 1 << ADDR_W;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] cells [DEPTH];

      always_ff @(posedge clk) begin
         if (we_lanes[g]) begin
            cells[waddr] <= wdata[g*LANE_W +: LANE_W];
         end
      end

      assign rdata_a[g*LANE_W +: LANE_W] = cells[raddr_a];
      assign rdata_b[g*LANE_W +: LANE_W] = cells[raddr_b];
   end
endmodule

// File: rtl/dpr_out_stage.sv
module dpr_out_stage
   import dpr_pkg::*;
#(
   parameter int LANE_W = 9,
   parameter int LANES  = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      pipe_sel,
   input  logic                      oe_n,
   input  logic [LANES*LANE_W-1:0]   rd_word,
   input  logic [LANES-1:0]          rd_lanes,
   output logic [LANES*LANE_W-1:0]   dout,
   output logic [LANES-1:0]          dout_en
);
   logic [LANES*LANE_W-1:0] word_q;
   logic [LANES-1:0]        lanes_q;
   logic [LANES-1:0]        lanes_sel;
   out_mode_e               mode;

   // extra stage: data and lane qualifiers move together, so a deselect
   // needs a second edge to reach the flags
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q  <= '0;
         lanes_q <= '0;
      end else begin
         word_q  <= rd_word;
         lanes_q <= rd_lanes;
      end
   end

   always_comb begin
      mode = out_mode_e'(pipe_sel);
      if (mode == OUT_PIPE) begin
         dout      = word_q;
         lanes_sel = lanes_q;
      end else begin
         dout      = rd_word;
         lanes_sel = rd_lanes;
      end
      dout_en = oe_n ? '0 : lanes_sel;
   end
endmodule

// File: rtl/dpr_dual_sync_ram.sv
module dpr_dual_sync_ram
   import dpr_pkg::*;
#(
   parameter int ADDR_W = DEF_ADDR_W,
   parameter int LANE_W = DEF_LANE_W,
   parameter int LANES  = DEF_LANES
) (
   input  logic                      clk_l,
   input  logic                      rst_n_l,
   input  logic                      pipe_l,
   input  logic                      ce0_n_l,
   input  logic                      ce1_l,
   input  logic                      rw_l,
   input  logic [LANES-1:0]          be_l,
   input  logic [ADDR_W-1:0]         addr_l,
   input  logic [LANES*LANE_W-1:0]   din_l,
   input  logic                      oe_n_l,
   output logic [LANES*LANE_W-1:0]   dout_l,
   output logic [LANES-1:0]          dout_en_l,
   input  logic                      clk_r,
   input  logic                      rst_n_r,
   input  logic                      pipe_r,
   input  logic                      ce0_n_r,
   input  logic                      ce1_r,
   input  logic                      rw_r,
   input  logic [LANES-1:0]          be_r,
   input  logic [ADDR_W-1:0]         addr_r,
   input  logic [LANES*LANE_W-1:0]   din_r,
   input  logic                      oe_n_r,
   output logic [LANES*LANE_W-1:0]   dout_r,
   output logic [LANES-1:0]          dout_en_r
);
   localparam int DATA_W = LANES * LANE_W;

   if (ADDR_W < 1 || ADDR_W > 20) begin : g_bad_addr_w
      $error("dpr_dual_sync_ram: ADDR_W must lie in 1..20");
   end
   if (LANE_W < 1) begin : g_bad_lane_w
      $error("dpr_dual_sync_ram: LANE_W must be at least 1");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("dpr_dual_sync_ram: LANES must be at least 1");
   end

   logic [LANES-1:0]  wr_l, rd_l, wr_r, rd_r, wr_r_eff;
   logic [ADDR_W-1:0] a_l, a_r;
   logic [DATA_W-1:0] d_l, d_r;
   logic [DATA_W-1:0] bl_at_l, bl_at_r, br_at_l, br_at_r;
   logic [DATA_W-1:0] word_l, word_r;

   dpr_port_front #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_front_l (
      .clk(clk_l), .rst_n(rst_n_l), .ce0_n(ce0_n_l), .ce1(ce1_l), .rw(rw_l),
      .be(be_l), .addr(addr_l), .din(din_l),
      .wr_lanes(wr_l), .rd_lanes(rd_l), .addr_q(a_l), .din_q(d_l)
   );

   dpr_port_front #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_front_r (
      .clk(clk_r), .rst_n(rst_n_r), .ce0_n(ce0_n_r), .ce1(ce1_r), .rw(rw_r),
      .be(be_r), .addr(addr_r), .din(din_r),
      .wr_lanes(wr_r), .rd_lanes(rd_r), .addr_q(a_r), .din_q(d_r)
   );

   // same word, same lane, same edge: the left request suppresses the right
   assign wr_r_eff = (a_l == a_r) ? (wr_r & ~wr_l) : wr_r;

   // each bank has one writer; a stored word is the XOR of both banks
   dpr_xor_bank #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_bank_l (
      .clk(clk_l), .we_lanes(wr_l), .waddr(a_l), .wdata(d_l ^ br_at_l),
      .raddr_a(a_l), .raddr_b(a_r), .rdata_a(bl_at_l), .rdata_b(bl_at_r)
   );

   dpr_xor_bank #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_bank_r (
      .clk(clk_r), .we_lanes(wr_r_eff), .waddr(a_r), .wdata(d_r ^ bl_at_r),
      .raddr_a(a_l), .raddr_b(a_r), .rdata_a(br_at_l), .rdata_b(br_at_r)
   );

   assign word_l = bl_at_l ^ br_at_l;
   assign word_r = bl_at_r ^ br_at_r;

   dpr_out_stage #(.LANE_W(LANE_W), .LANES(LANES)) u_out_l (
      .clk(clk_l), .rst_n(rst_n_l), .pipe_sel(pipe_l), .oe_n(oe_n_l),
      .rd_word(word_l), .rd_lanes(rd_l), .dout(dout_l), .dout_en(dout_en_l)
   );

   dpr_out_stage #(.LANE_W(LANE_W), .LANES(LANES)) u_out_r (
      .clk(clk_r), .rst_n(rst_n_r), .pipe_sel(pipe_r), .oe_n(oe_n_r),
      .rd_word(word_r), .rd_lanes(rd_r), .dout(dout_r), .dout_en(dout_en_r)
   );
endmodule

// File: rtl/dpr_dual_sync_ram_chk.sv
module dpr_dual_sync_ram_chk #(
   parameter int LANES = 4
) (
   input logic             clk_l,
   input logic             rst_n_l,
   input logic             pipe_l,
   input logic             ce0_n_l,
   input logic             ce1_l,
   input logic             rw_l,
   input logic [LANES-1:0] be_l,
   input logic             oe_n_l,
   input logic [LANES-1:0] dout_en_l,
   input logic             clk_r,
   input logic             rst_n_r,
   input logic             pipe_r,
   input logic             ce0_n_r,
   input logic             ce1_r,
   input logic             rw_r,
   input logic [LANES-1:0] be_r,
   input logic             oe_n_r,
   input logic [LANES-1:0] dout_en_r
);
   always @(posedge clk_l) begin
      if (!rst_n_l) begin
         a_r1_reset_quiet_l: assert (dout_en_l == '0);
      end
   end

   a_r6_oe_gates_l: assert property (@(posedge clk_l) disable iff (!rst_n_l)
      oe_n_l |-> dout_en_l == '0);

   a_r3_flow_desel_l: assert property (@(posedge clk_l) disable iff (!rst_n_l)
      (!pipe_l && $past(ce0_n_l || !ce1_l)) |-> dout_en_l == '0);

   a_r5_pipe_read_l: assert property (@(posedge clk_l) disable iff (!rst_n_l)
      (pipe_l && !oe_n_l && $past(!ce0_n_l && ce1_l && rw_l, 2))
      |-> dout_en_l == $past(be_l, 2));

   a_r5_pipe_desel_r: assert property (@(posedge clk_r) disable iff (!rst_n_r)
      (pipe_r && $past(ce0_n_r || !ce1_r, 2)) |-> dout_en_r == '0);

   a_r4_flow_read_r: assert property (@(posedge clk_r) disable iff (!rst_n_r)
      (!pipe_r && !oe_n_r && $past(!ce0_n_r && ce1_r && rw_r))
      |-> dout_en_r == $past(be_r));
endmodule

bind dpr_dual_sync_ram dpr_dual_sync_ram_chk #(.LANES(LANES)) u_chk (
   .clk_l(clk_l), .rst_n_l(rst_n_l), .pipe_l(pipe_l), .ce0_n_l(ce0_n_l),
   .ce1_l(ce1_l), .rw_l(rw_l), .be_l(be_l), .oe_n_l(oe_n_l), .dout_en_l(dout_en_l),
   .clk_r(clk_r), .rst_n_r(rst_n_r), .pipe_r(pipe_r), .ce0_n_r(ce0_n_r),
   .ce1_r(ce1_r), .rw_r(rw_r), .be_r(be_r), .oe_n_r(oe_n_r), .dout_en_r(dout_en_r)
);

// File: tb/dpr_dual_sync_ram_tb_top.sv
module dpr_dual_sync_ram_tb_top;
   localparam int AW = 8;
   localparam int LN = 4;
   localparam int LW = 9;
   localparam int DW = LN * LW;
   localparam int DEPTH = 1 << AW;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst_n;
   logic pipe_l, ce0_n_l, ce1_l, rw_l, oe_n_l;
   logic pipe_r, ce0_n_r, ce1_r, rw_r, oe_n_r;
   logic [LN-1:0] be_l, be_r, den_l, den_r;
   logic [AW-1:0] addr_l, addr_r;
   logic [DW-1:0] din_l, din_r, dout_l, dout_r;

   dpr_dual_sync_ram #(.ADDR_W(AW), .LANE_W(LW), .LANES(LN)) dut_i (
      .clk_l(clk), .rst_n_l(rst_n), .pipe_l(pipe_l), .ce0_n_l(ce0_n_l), .ce1_l(ce1_l),
      .rw_l(rw_l), .be_l(be_l), .addr_l(addr_l), .din_l(din_l), .oe_n_l(oe_n_l),
      .dout_l(dout_l), .dout_en_l(den_l),
      .clk_r(clk), .rst_n_r(rst_n), .pipe_r(pipe_r), .ce0_n_r(ce0_n_r), .ce1_r(ce1_r),
      .rw_r(rw_r), .be_r(be_r), .addr_r(addr_r), .din_r(din_r), .oe_n_r(oe_n_r),
      .dout_r(dout_r), .dout_en_r(den_r)
   );

   // behavioural reference
   logic [DW-1:0] mref [DEPTH];
   logic          pw_v  [2];
   logic [AW-1:0] pw_a  [2];
   logic [DW-1:0] pw_d  [2];
   logic [LN-1:0] pw_be [2];
   logic [LN-1:0] ft_ln [2];
   logic [LN-1:0] pp_ln [2];
   logic [DW-1:0] ft_d  [2];
   logic [DW-1:0] pp_d  [2];

   int    n_cmp = 0;
   int    n_bad = 0;
   string req_tag = "R1";

   task automatic commit(input int p);
      for (int l = 0; l < LN; l++) begin
         if (pw_be[p][l]) mref[pw_a[p]][l*LW +: LW] = pw_d[p][l*LW +: LW];
      end
   endtask

   task automatic capture(input int p, input logic c0n, input logic c1, input logic rw,
                          input logic [LN-1:0] be, input logic [AW-1:0] a,
                          input logic [DW-1:0] d);
      logic sel;
      sel      = !c0n && c1;
      pw_v[p]  = sel && !rw;
      pw_a[p]  = a;
      pw_d[p]  = d;
      pw_be[p] = be;
      ft_ln[p] = (sel && rw) ? be : '0;
      ft_d[p]  = mref[a];
   endtask

   task automatic model_edge();
      for (int p = 0; p < 2; p++) begin
         pp_ln[p] = ft_ln[p];
         pp_d[p]  = ft_d[p];
      end
      if (!rst_n) begin
         for (int p = 0; p < 2; p++) begin
            pw_v[p] = 1'b0; ft_ln[p] = '0; pp_ln[p] = '0;
         end
      end else begin
         // right commits first, so the left port wins shared lanes (R8)
         if (pw_v[1]) commit(1);
         if (pw_v[0]) commit(0);
         capture(0, ce0_n_l, ce1_l, rw_l, be_l, addr_l, din_l);
         capture(1, ce0_n_r, ce1_r, rw_r, be_r, addr_r, din_r);
      end
   endtask

   task automatic check_port(input int p);
      logic [LN-1:0] got_en, exp_en;
      logic [DW-1:0] got_d, exp_d, msk;
      logic pm, oen;
      if (p == 0) begin
         got_en = den_l; got_d = dout_l; pm = pipe_l; oen = oe_n_l;
      end else begin
         got_en = den_r; got_d = dout_r; pm = pipe_r; oen = oe_n_r;
      end
      exp_en = oen ? '0 : (pm ? pp_ln[p] : ft_ln[p]);
      exp_d  = pm ? pp_d[p] : ft_d[p];
      for (int l = 0; l < LN; l++) msk[l*LW +: LW] = {LW{exp_en[l]}};
      n_cmp++;
      if (got_en !== exp_en || (got_d & msk) !== (exp_d & msk)) begin
         n_bad++;
         $display("FAIL %s port %0d: drive=%b data=%h, expected drive=%b data=%h",
                  req_tag, p, got_en, got_d & msk, exp_en, exp_d & msk);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      model_edge();
      @(negedge clk);
      check_port(0);
      check_port(1);
   endtask

   task automatic drv(input int p, input logic c0n, input logic c1, input logic rw,
                      input logic oen, input logic [LN-1:0] be, input logic [AW-1:0] a,
                      input logic [DW-1:0] d);
      if (p == 0) begin
         ce0_n_l = c0n; ce1_l = c1; rw_l = rw; oe_n_l = oen; be_l = be; addr_l = a; din_l = d;
      end else begin
         ce0_n_r = c0n; ce1_r = c1; rw_r = rw; oe_n_r = oen; be_r = be; addr_r = a; din_r = d;
      end
   endtask

   task automatic idle(input int p);
      drv(p, 1'b1, 1'b0, 1'b1, 1'b0, '0, '0, '0);
   endtask

   task automatic rd(input int p, input logic [AW-1:0] a, input logic [LN-1:0] be,
                     input logic oen);
      drv(p, 1'b0, 1'b1, 1'b1, oen, be, a, '0);
   endtask

   task automatic wr(input int p, input logic [AW-1:0] a, input logic [LN-1:0] be,
                     input logic [DW-1:0] d);
      drv(p, 1'b0, 1'b1, 1'b0, 1'b0, be, a, d);
   endtask

   function automatic logic [DW-1:0] pat(input int a);
      logic [7:0] b;
      b = 8'(a);
      return {b, ~b, b ^ 8'h5a, ~b ^ 8'h33, 4'ha};
   endfunction

   initial begin
      #(8 * 100000);
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      rst_n = 1'b1;
      pipe_l = 1'b1;
      pipe_r = 1'b0;
      idle(0);
      idle(1);
      #1 rst_n = 1'b0;
      // R1: flags quiet in reset and just after release
      req_tag = "R1";
      repeat (3) tick();
      rst_n = 1'b1;
      tick();

      // R10: fill every word from the left, right reads the word written one edge earlier
      req_tag = "R10";
      for (int a = 0; a < DEPTH; a++) begin
         wr(0, AW'(a), 4'hf, pat(a));
         if (a > 0) rd(1, AW'(a - 1), 4'hf, 1'b0);
         else idle(1);
         tick();
      end

      // R4 (right, flow-through) and R5 (left, pipelined) read streams
      req_tag = "R4";
      for (int a = 0; a < 16; a++) begin
         rd(0, AW'(a), 4'hf, 1'b0);
         rd(1, AW'(a + 16), 4'hf, 1'b0);
         tick();
      end

      // R2: partial lane write keeps the other lanes
      req_tag = "R2";
      wr(0, 8'd5, 4'b0101, 36'h0);
      idle(1);
      tick();
      rd(0, 8'd5, 4'hf, 1'b0);
      rd(1, 8'd5, 4'hf, 1'b0);
      tick();
      idle(0); idle(1);
      tick(); tick();

      // R3: a write with either select inactive changes nothing, reads do not drive
      req_tag = "R3";
      drv(0, 1'b1, 1'b1, 1'b0, 1'b0, 4'hf, 8'd6, 36'hfffffffff);
      drv(1, 1'b0, 1'b0, 1'b0, 1'b0, 4'hf, 8'd6, 36'h123456789);
      tick();
      drv(0, 1'b1, 1'b1, 1'b1, 1'b0, 4'hf, 8'd7, '0);
      drv(1, 1'b0, 1'b0, 1'b1, 1'b0, 4'hf, 8'd7, '0);
      tick();
      rd(0, 8'd6, 4'hf, 1'b0);
      rd(1, 8'd6, 4'hf, 1'b0);
      tick(); tick();

      // R5: deselect on the pipelined port takes two edges
      req_tag = "R5";
      rd(0, 8'd8, 4'hf, 1'b0);
      idle(1);
      tick();
      idle(0);
      tick(); tick();

      // R6: per-lane flags follow lane enables and output-enable
      req_tag = "R6";
      rd(0, 8'd9, 4'b1010, 1'b0);
      rd(1, 8'd9, 4'b0110, 1'b1);
      tick();
      rd(0, 8'd9, 4'b0001, 1'b1);
      rd(1, 8'd9, 4'b1001, 1'b0);
      tick();
      oe_n_l = 1'b0;
      tick();

      // R7: same word read by both ports
      req_tag = "R7";
      rd(0, 8'd10, 4'hf, 1'b0);
      rd(1, 8'd10, 4'hf, 1'b0);
      tick(); tick();

      // R8: colliding writes with overlapping lane masks
      req_tag = "R8";
      wr(0, 8'd11, 4'b0011, 36'h111111111);
      wr(1, 8'd11, 4'b0110, 36'h222222222);
      tick();
      rd(0, 8'd11, 4'hf, 1'b0);
      rd(1, 8'd11, 4'hf, 1'b0);
      tick();
      idle(0); idle(1);
      tick(); tick();

      // R9: read alongside a write to the same word returns the old value
      req_tag = "R9";
      wr(0, 8'd12, 4'hf, 36'h0abcdef01);
      rd(1, 8'd12, 4'hf, 1'b0);
      tick();
      idle(0);
      rd(1, 8'd12, 4'hf, 1'b0);
      tick();
      wr(1, 8'd13, 4'hf, 36'h987654321);
      rd(0, 8'd13, 4'hf, 1'b0);
      tick();
      idle(1);
      rd(0, 8'd13, 4'hf, 1'b0);
      tick();
      idle(0);
      tick(); tick();

      // swap timing modes and mix collisions at random over four words
      req_tag = "R8";
      pipe_l = 1'b0;
      pipe_r = 1'b1;
      for (int i = 0; i < 400; i++) begin
         for (int p = 0; p < 2; p++) begin
            int op;
            logic oen;
            op  = int'($urandom % 5);
            oen = ($urandom % 4) == 0;
            case (op)
               0, 1: drv(p, 1'b0, 1'b1, 1'b1, oen, 4'($urandom), AW'($urandom % 4), '0);
               2, 3: drv(p, 1'b0, 1'b1, 1'b0, oen, 4'($urandom), AW'($urandom % 4),
                         {4'($urandom), 32'($urandom)});
               default: drv(p, 1'($urandom), 1'($urandom), 1'($urandom), oen,
                            4'($urandom), AW'($urandom % 4), 36'hfffffffff);
            endcase
         end
         tick();
      end
      idle(0); idle(1);
      tick(); tick();

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule